// File: doc/BRIEF.md
# Burst Beat Address Generator

This block supplies the address for every beat of a burst that is four beats long by default. An external start address is captured when either of two active-low load strobes is low at a rising clock edge. After that, only the lowest address bits are produced internally while the upper bits keep the captured value. Each step of the burst moves those low bits through a fixed order.

A static order-select input chooses between two orders. The first is a linear order that counts upward and wraps. The second is an interleaved order in which the captured low bits are XORed with a beat count. An active-low advance input steps the burst. While advance is high, the current beat address is held, which gives a wait cycle. Advancing past the last beat returns the sequence to the captured start address.

The block sits between a bus front end and a memory array, in the address path only. The output is a register, so each new beat address appears on the clock edge that accepts the command.

Top module: `burst_addr_gen`

## Requirements
- R1: While no load occurs, the address bits above the generated low field (bits 15..2 at default parameters) keep the value captured at the last load.
- R2: With `order_sel` = 0 (linear), the low field of beat k equals the captured low bits plus k, modulo 4. For example, start 01 gives 01, 10, 11, 00.
- R3: With `order_sel` = 1 (interleaved), the low field of beat k equals the captured low bits XOR k. Start 01 gives 01, 00, 11, 10. Start 10 gives 10, 11, 00, 01. Start 11 gives 11, 10, 01, 00.
- R4: When `load_a_n` or `load_b_n` (or both) is low at a rising edge, `beat_addr` equals `ext_addr` after that edge, and the beat count restarts at 0.
- R5: With both loads high, an edge with `adv_n` low moves to the next beat. An edge with `adv_n` high leaves `beat_addr` unchanged (wait cycle).
- R6: An advance from the fourth beat returns `beat_addr` to the captured start address.
- R7: A load has priority over an advance in the same cycle. The captured address is presented and the following advance gives beat 1.
- R8: A synchronous active-high `rst` forces `beat_addr` to 0 and the beat count to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_a_n | input | 1 | Load strobe A, active low |
| load_b_n | input | 1 | Load strobe B, active low |
| adv_n | input | 1 | Advance to next beat, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| ext_addr | input | 16 | External start address |
| beat_addr | output | 16 | Registered address of the current beat |

## Verification
Every result is due one edge after the command that causes it: a load, an advance, a wait or a reset sampled at edge n appears on `beat_addr` after edge n and holds until edge n+1. The bench drives inputs on the falling edge and advances its reference model at the rising edge. It compares at the next falling edge, so each comparison falls exactly one register stage after its stimulus. The directed bursts add checks against literal beat values for both orders.

// File: rtl/burst_gen_pkg.sv
package burst_gen_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

endpackage

// File: rtl/beat_counter.sv
module beat_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_comb begin
    if (clr)       cnt_nxt = '0;
    else if (step) cnt_nxt = cnt_q + 1'b1;
    else           cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));  // R7

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && !clr && cnt_q == CNT_MAX) |=> (cnt_q == '0));  // R6

  AST_CNT_WAIT: assert property (@(posedge clk) disable iff (rst)
    (!step && !clr) |=> $stable(cnt_q));  // R5

endmodule

// File: rtl/beat_order_map.sv
module beat_order_map
  import burst_gen_pkg::*;
#(
  parameter int LOW_W = 2
) (
  input  order_e           order,
  input  logic [LOW_W-1:0] base,
  input  logic [LOW_W-1:0] cnt,
  output logic [LOW_W-1:0] low
);

  logic [LOW_W-1:0] lin_low;
  logic [LOW_W-1:0] xor_low;

  assign lin_low = base + cnt;

  for (genvar b = 0; b < LOW_W; b++) begin : g_xor_bit
    assign xor_low[b] = base[b] ^ cnt[b];
  end

  assign low = (order == ORD_XOR) ? xor_low : lin_low;

endmodule

// File: rtl/start_addr_reg.sv
module start_addr_reg #(
  parameter int ADDR_W = 16,
  parameter int LOW_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:LOW_W] upper_q,
  output logic [LOW_W-1:0]  base_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= '0;
      base_q  <= '0;
    end else if (load) begin
      upper_q <= ext_addr[ADDR_W-1:LOW_W];
      base_q  <= ext_addr[LOW_W-1:0];
    end
  end

  AST_START_HELD: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(upper_q) && $stable(base_q)));  // R1

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_gen_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LOW_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_a_n,
  input  logic              load_b_n,
  input  logic              adv_n,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] beat_addr
);

  localparam int UP_W = ADDR_W - LOW_W;

  logic                   load;
  logic                   step;
  order_e                 order;
  logic [ADDR_W-1:LOW_W]  upper_q;
  logic [LOW_W-1:0]       base_q;
  logic [LOW_W-1:0]       cnt_q;
  logic [LOW_W-1:0]       cnt_nxt;
  logic [LOW_W-1:0]       low_nxt;
  logic [ADDR_W-1:0]      beat_q;
  logic [LOW_W-1:0]       out_low;
  logic [UP_W-1:0]        out_up;

  assign load  = !load_a_n || !load_b_n;
  assign step  = !adv_n && !load;
  assign order = order_e'(order_sel);

  start_addr_reg #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_start (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .ext_addr (ext_addr),
    .upper_q  (upper_q),
    .base_q   (base_q)
  );

  beat_counter #(.CNT_W(LOW_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (load),
    .step    (step),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt)
  );

  beat_order_map #(.LOW_W(LOW_W)) u_map (
    .order (order),
    .base  (base_q),
    .cnt   (cnt_nxt),
    .low   (low_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)       beat_q <= '0;
    else if (load) beat_q <= ext_addr;
    else if (step) beat_q <= {upper_q, low_nxt};
  end

  assign beat_addr = beat_q;
  assign out_low   = beat_q[LOW_W-1:0];
  assign out_up    = beat_q[ADDR_W-1:LOW_W];

  AST_LOAD_TAKES_EXT: assert property (@(posedge clk) disable iff (rst)
    load |=> (beat_addr == $past(ext_addr)));  // R4

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    !load |=> (out_up == $past(out_up)));  // R1

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!load && adv_n) |=> $stable(beat_addr));  // R5

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && order == ORD_LINEAR && $stable(order_sel)) |=>
      ((out_low - $past(out_low)) == LOW_W'(1)));  // R2

  AST_XOR_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && order == ORD_XOR) |=>
      ((out_low ^ $past(out_low)) == (cnt_q ^ $past(cnt_q))));  // R3

endmodule

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/1ps
module burst_addr_gen_bench;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_a_n = 1'b1;
  logic          load_b_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          order_sel = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] beat_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [AW-3:0] m_up = '0;
  logic [1:0]    m_base = '0;
  logic [1:0]    m_cnt = '0;
  logic [AW-1:0] m_out = '0;

  always #4 clk = ~clk;

  burst_addr_gen u_burst_addr_gen (
    .clk       (clk),
    .rst       (rst),
    .load_a_n  (load_a_n),
    .load_b_n  (load_b_n),
    .adv_n     (adv_n),
    .order_sel (order_sel),
    .ext_addr  (ext_addr),
    .beat_addr (beat_addr)
  );

  function automatic logic [1:0] beat_low(input logic mode, input logic [1:0] b, input logic [1:0] k);
    return mode ? (b ^ k) : (b + k);
  endfunction

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: inputs already driven at falling edge; model at rising edge; compare at next falling edge
  task automatic cyc();
    string tag;
    logic  ld;
    ld = !load_a_n || !load_b_n;
    if (rst)              tag = "R8";
    else if (ld && !adv_n) tag = "R7";
    else if (ld)          tag = "R4";
    else if (adv_n)       tag = "R5";
    else if (m_cnt == 2'd3) tag = "R6";
    else                  tag = order_sel ? "R3" : "R2";
    @(posedge clk);
    if (rst) begin
      m_up = '0; m_base = '0; m_cnt = '0; m_out = '0;
    end else if (ld) begin
      m_up = ext_addr[AW-1:2]; m_base = ext_addr[1:0]; m_cnt = '0; m_out = ext_addr;
    end else if (!adv_n) begin
      m_cnt = m_cnt + 2'd1;
      m_out = {m_up, beat_low(order_sel, m_base, m_cnt)};
    end
    @(negedge clk);
    check(tag, beat_addr, m_out);
    if (!rst) check("R1", {14'd0, beat_addr[AW-1:2]}, {14'd0, m_up});
  endtask

  task automatic drive(input logic la, input logic lb, input logic av, input logic [AW-1:0] a);
    load_a_n = la; load_b_n = lb; adv_n = av; ext_addr = a;
  endtask

  task automatic burst_lit(input logic mode, input logic [1:0] start, input string tag,
                           input logic [1:0] b1, input logic [1:0] b2, input logic [1:0] b3);
    order_sel = mode;
    drive(1'b0, 1'b1, 1'b1, {14'h2A5C, start}); cyc();
    drive(1'b1, 1'b1, 1'b0, 16'hFFFF);
    cyc(); check(tag, {14'd0, beat_addr[1:0]}, {14'd0, b1});
    cyc(); check(tag, {14'd0, beat_addr[1:0]}, {14'd0, b2});
    cyc(); check(tag, {14'd0, beat_addr[1:0]}, {14'd0, b3});
    cyc(); check("R6", beat_addr, {14'h2A5C, start});
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1207));
    @(negedge clk);
    cyc(); cyc();
    check("R8", beat_addr, 16'h0000);
    rst = 1'b0;

    // directed orders
    burst_lit(1'b0, 2'b01, "R2", 2'b10, 2'b11, 2'b00);
    burst_lit(1'b1, 2'b01, "R3", 2'b00, 2'b11, 2'b10);
    burst_lit(1'b1, 2'b10, "R3", 2'b11, 2'b00, 2'b01);
    burst_lit(1'b1, 2'b11, "R3", 2'b10, 2'b01, 2'b00);

    // strobe B alone, with a wait cycle in the burst
    order_sel = 1'b0;
    drive(1'b1, 1'b0, 1'b1, 16'h8003); cyc();
    check("R4", beat_addr, 16'h8003);
    drive(1'b1, 1'b1, 1'b1, 16'h1234); cyc();
    check("R5", beat_addr, 16'h8003);
    drive(1'b1, 1'b1, 1'b0, 16'h1234); cyc();
    check("R2", beat_addr, 16'h8000);

    // load and advance together
    drive(1'b0, 1'b0, 1'b0, 16'h4C46); cyc();
    check("R7", beat_addr, 16'h4C46);
    drive(1'b1, 1'b1, 1'b0, 16'h0000); cyc();
    check("R7", beat_addr, 16'h4C47);

    // reset mid-burst
    rst = 1'b1; cyc(); check("R8", beat_addr, 16'h0000); rst = 1'b0;

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r;
      r = 4'($urandom_range(0, 15));
      if (r == 4'd0 || r == 4'd1) order_sel = 1'($urandom);
      if (r <= 4'd1)      drive(1'b0, 1'($urandom), 1'($urandom), 16'($urandom));
      else if (r == 4'd2) drive(1'b1, 1'b0, 1'($urandom), 16'($urandom));
      else                drive(1'b1, 1'b1, (r >= 4'd12), 16'($urandom));
      if (r <= 4'd1 && !load_a_n) load_a_n = 1'b0;
      if (($urandom_range(0, 299)) == 0) rst = 1'b1;
      cyc();
      rst = 1'b0;
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule